// File: doc/BRIEF.md
# Keyed Opcode Permutation Generator

This block derives a secret byte permutation from a short key and then uses it to turn scrambled opcode bytes back into operation numbers. An assembler scrambles each opcode by replacing operation number `p` with entry `p` of the permutation. The decoder therefore needs the inverse of that permutation: given the scrambled byte, it must find the position holding that value.

Software or a loader first writes up to `KEY_MAX` key bytes through a small write port. It then pulses `start` together with the key length. The generator sets up a 256-entry identity table. It then runs the byte-swapping key schedule, one step every two clock cycles. While it swaps, it keeps an inverse table up to date, so decode is ready the moment the last swap retires. After `done` rises, each lookup request returns the operation index one cycle later. A `lu_known` bit tells the caller whether that index names a defined operation.

Top module: `opkey_perm_gen`

## Requirements
- R1: While and after synchronous reset, `busy`, `done` and `lu_rvalid` are low until a shuffle is started or a lookup is requested.
- R2: A `start` sampled with `key_len` between 1 and `KEY_MAX` while not busy starts a shuffle. `busy` is high and `done` low from the next edge onward. `done` rises on exactly the 513th rising edge after the edge that sampled `start`.
- R3: The table starts as S[i] = i. For i = 0 to 255 in order, with j starting at 0, the shuffle computes j = (j + S[i] + key[i mod key_len]) mod 256 and then swaps S[i] and S[j]. Key byte n is the byte last written at `key_addr` = n.
- R4: Every cycle with `lu_req` high yields `lu_rvalid` high on the next cycle, with `lu_index` equal to the position p for which S[p] equals `lu_code`. `lu_rvalid` is low after a cycle without a request.
- R5: `lu_known` is high only if `done` was high in the request cycle and `lu_index` is below `NUM_OPS` (default 49).
- R6: A `start` with `key_len` of 0 or above `KEY_MAX` is ignored. `busy` stays low and `done` keeps its value.
- R7: A `start` while busy is ignored. The running shuffle keeps its key length, its completion edge and its result.
- R8: Key writes while busy are ignored. A later shuffle with the same length yields the same table as before the ignored write.
- R9: A valid `start` while `done` is high restarts the shuffle, and `done` falls on the next edge. A lookup requested in that same cycle is answered from the previous table, with `lu_known` high when its index is below `NUM_OPS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_wr | input | 1 | Key byte write strobe |
| key_addr | input | $clog2(KEY_MAX) | Key byte position |
| key_byte | input | 8 | Key byte value |
| key_len | input | $clog2(KEY_MAX+1) | Number of key bytes used, sampled with start |
| start | input | 1 | Begin a shuffle |
| lu_req | input | 1 | Lookup request |
| lu_code | input | 8 | Scrambled opcode byte to translate |
| busy | output | 1 | Shuffle in progress |
| done | output | 1 | Table ready for decoding |
| lu_rvalid | output | 1 | Lookup response valid |
| lu_index | output | 8 | Operation index for the requested byte |
| lu_known | output | 1 | Index names a defined operation and table was ready |

## Verification
Two functions can collide in one cycle: a restart of the shuffle and a lookup. The bench provokes this by raising `start` and `lu_req` on the same clock after a finished run, with new key bytes already written. It then requires the response to match the previous key's inverse table with `lu_known` set. It also requires `done` to be low on the following cycle and the new table to match the new key once the restart completes. A second overlap is a `start` or key write that lands mid-shuffle. That run is judged by its unchanged completion edge and its unchanged table.

// File: rtl/opkey_pkg.sv
package opkey_pkg;

    localparam int SYM_W = 8;
    localparam int SYM_N = 1 << SYM_W;
    localparam int RUN_CYC = 2 * SYM_N + 1;

    typedef logic [SYM_W-1:0] sym_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_INIT,
        PH_READ,
        PH_SWAP,
        PH_DONE
    } phase_e;

    // One exchange of two table slots: slot pos_a holds val_a, slot pos_b holds val_b.
    typedef struct packed {
        logic en;
        sym_t pos_a;
        sym_t pos_b;
        sym_t val_a;
        sym_t val_b;
    } swap_req_t;

    typedef struct packed {
        logic valid;
        sym_t index;
        logic known;
    } lookup_rsp_t;

    function automatic sym_t mix_step(sym_t acc, sym_t slot, sym_t kbyte);
        sym_t sum;
        sum = acc + slot + kbyte;
        return sum;
    endfunction

    function automatic logic last_pos(sym_t pos);
        return pos == sym_t'(SYM_N - 1);
    endfunction

endpackage

// File: rtl/opkey_key_bank.sv
module opkey_key_bank
    import opkey_pkg::*;
#(
    parameter int KEY_MAX = 16,
    parameter int KEY_AW  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [KEY_AW-1:0] wr_addr,
    input  sym_t              wr_data,
    input  logic              lock,
    input  logic [KEY_AW-1:0] rd_idx,
    output sym_t              rd_data
);

    sym_t bank [KEY_MAX];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < KEY_MAX; k++) begin
                bank[k] <= '0;
            end
        end else if (wr_en && !lock && (int'(wr_addr) < KEY_MAX)) begin
            bank[wr_addr] <= wr_data;
        end
    end

    assign rd_data = bank[rd_idx];

endmodule

// File: rtl/opkey_ksa_ctrl.sv
module opkey_ksa_ctrl
    import opkey_pkg::*;
#(
    parameter int KEY_MAX = 16,
    parameter int KEY_AW  = 4,
    parameter int LEN_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LEN_W-1:0]  key_len,
    input  sym_t              key_byte,
    output logic [KEY_AW-1:0] key_idx,
    output sym_t              rd_addr,
    input  sym_t              rd_data,
    output logic              init_o,
    output swap_req_t         swap_o,
    output logic              busy,
    output logic              done
);

    phase_e             ph;
    sym_t               pos_i;
    sym_t               acc_j;
    sym_t               hold_val;
    sym_t               hold_j;
    logic [KEY_AW-1:0]  kidx;
    logic [LEN_W-1:0]   klen;
    logic [LEN_W-1:0]   knext;
    logic               kwrap;
    logic               len_ok;
    logic               accept;

    assign len_ok = (key_len != '0) && (int'(key_len) <= KEY_MAX);
    assign accept = start && len_ok && ((ph == PH_IDLE) || (ph == PH_DONE));
    assign knext  = LEN_W'(kidx) + LEN_W'(1);
    assign kwrap  = (knext == klen);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            pos_i    <= '0;
            acc_j    <= '0;
            hold_val <= '0;
            hold_j   <= '0;
            kidx     <= '0;
            klen     <= '0;
        end else begin
            case (ph)
                PH_IDLE, PH_DONE: begin
                    if (accept) begin
                        ph   <= PH_INIT;
                        klen <= key_len;
                    end
                end
                PH_INIT: begin
                    ph    <= PH_READ;
                    pos_i <= '0;
                    acc_j <= '0;
                    kidx  <= '0;
                end
                PH_READ: begin
                    hold_val <= rd_data;
                    hold_j   <= mix_step(acc_j, rd_data, key_byte);
                    ph       <= PH_SWAP;
                end
                PH_SWAP: begin
                    acc_j <= hold_j;
                    pos_i <= pos_i + sym_t'(1);
                    kidx  <= kwrap ? '0 : KEY_AW'(knext);
                    ph    <= last_pos(pos_i) ? PH_DONE : PH_READ;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_addr      = (ph == PH_SWAP) ? hold_j : pos_i;
        key_idx      = kidx;
        init_o       = (ph == PH_INIT);
        swap_o.en    = (ph == PH_SWAP);
        swap_o.pos_a = pos_i;
        swap_o.pos_b = hold_j;
        swap_o.val_a = hold_val;
        swap_o.val_b = rd_data;
        busy         = (ph == PH_INIT) || (ph == PH_READ) || (ph == PH_SWAP);
        done         = (ph == PH_DONE);
    end

endmodule

// File: rtl/opkey_perm_store.sv
module opkey_perm_store
    import opkey_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      init,
    input  swap_req_t swap_req,
    input  sym_t      rd_addr,
    output sym_t      rd_data,
    input  sym_t      lu_addr,
    output sym_t      lu_data
);

    sym_t fwd [SYM_N];
    sym_t inv [SYM_N];

    // Forward and inverse tables move together: each swap rewrites two
    // forward slots and the two inverse slots that point back at them.
    always_ff @(posedge clk) begin
        if (rst || init) begin
            for (int k = 0; k < SYM_N; k++) begin
                fwd[k] <= sym_t'(k);
                inv[k] <= sym_t'(k);
            end
        end else if (swap_req.en) begin
            fwd[swap_req.pos_a] <= swap_req.val_b;
            fwd[swap_req.pos_b] <= swap_req.val_a;
            inv[swap_req.val_a] <= swap_req.pos_b;
            inv[swap_req.val_b] <= swap_req.pos_a;
        end
    end

    assign rd_data = fwd[rd_addr];
    assign lu_data = inv[lu_addr];

endmodule

// File: rtl/opkey_lookup.sv
module opkey_lookup
    import opkey_pkg::*;
#(
    parameter int NUM_OPS = 49
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req,
    input  logic        ready,
    input  sym_t        tbl_data,
    output lookup_rsp_t rsp
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp <= '0;
        end else begin
            rsp.valid <= req;
            rsp.index <= tbl_data;
            rsp.known <= req && ready && (int'(tbl_data) < NUM_OPS);
        end
    end

endmodule

// File: rtl/opkey_perm_gen.sv
module opkey_perm_gen
    import opkey_pkg::*;
#(
    parameter  int KEY_MAX = 16,
    parameter  int NUM_OPS = 49,
    localparam int KEY_AW  = $clog2(KEY_MAX),
    localparam int LEN_W   = $clog2(KEY_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_wr,
    input  logic [KEY_AW-1:0] key_addr,
    input  logic [7:0]        key_byte,
    input  logic [LEN_W-1:0]  key_len,
    input  logic              start,
    input  logic              lu_req,
    input  logic [7:0]        lu_code,
    output logic              busy,
    output logic              done,
    output logic              lu_rvalid,
    output logic [7:0]        lu_index,
    output logic              lu_known
);

    logic [KEY_AW-1:0] kidx;
    sym_t              kbyte;
    sym_t              rd_addr;
    sym_t              rd_data;
    sym_t              inv_data;
    logic              init_tbl;
    swap_req_t         swap_req;
    lookup_rsp_t       rsp;
    logic              busy_w;
    logic              done_w;

    opkey_key_bank #(
        .KEY_MAX (KEY_MAX),
        .KEY_AW  (KEY_AW)
    ) u_keys (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (key_wr),
        .wr_addr (key_addr),
        .wr_data (key_byte),
        .lock    (busy_w),
        .rd_idx  (kidx),
        .rd_data (kbyte)
    );

    opkey_ksa_ctrl #(
        .KEY_MAX (KEY_MAX),
        .KEY_AW  (KEY_AW),
        .LEN_W   (LEN_W)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .key_len  (key_len),
        .key_byte (kbyte),
        .key_idx  (kidx),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .init_o   (init_tbl),
        .swap_o   (swap_req),
        .busy     (busy_w),
        .done     (done_w)
    );

    opkey_perm_store u_store (
        .clk      (clk),
        .rst      (rst),
        .init     (init_tbl),
        .swap_req (swap_req),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .lu_addr  (lu_code),
        .lu_data  (inv_data)
    );

    opkey_lookup #(
        .NUM_OPS (NUM_OPS)
    ) u_lookup (
        .clk      (clk),
        .rst      (rst),
        .req      (lu_req),
        .ready    (done_w),
        .tbl_data (inv_data),
        .rsp      (rsp)
    );

    assign busy      = busy_w;
    assign done      = done_w;
    assign lu_rvalid = rsp.valid;
    assign lu_index  = rsp.index;
    assign lu_known  = rsp.known;

endmodule

// File: rtl/opkey_perm_gen_chk.sv
module opkey_perm_gen_chk
    import opkey_pkg::*;
#(
    parameter  int KEY_MAX = 16,
    parameter  int NUM_OPS = 49,
    localparam int KEY_AW  = $clog2(KEY_MAX),
    localparam int LEN_W   = $clog2(KEY_MAX + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              key_wr,
    input logic [KEY_AW-1:0] key_addr,
    input logic [7:0]        key_byte,
    input logic [LEN_W-1:0]  key_len,
    input logic              start,
    input logic              lu_req,
    input logic [7:0]        lu_code,
    input logic              busy,
    input logic              done,
    input logic              lu_rvalid,
    input logic [7:0]        lu_index,
    input logic              lu_known
);

    logic [15:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + 16'd1;
        end else begin
            run_len <= '0;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!busy && !done && !lu_rvalid)); // R1

    AST_BUSY_EXCLUDES_DONE: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done); // R2

    AST_SHUFFLE_CYCLES: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_len == 16'(RUN_CYC))); // R2

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        lu_req |=> lu_rvalid); // R4

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !lu_req |=> !lu_rvalid); // R4

    AST_KNOWN_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (lu_rvalid && lu_known) |-> (int'(lu_index) < NUM_OPS)); // R5

    AST_KNOWN_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        (lu_req && !done) |=> !lu_known); // R5

    AST_BAD_LEN_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && ((key_len == '0) || (int'(key_len) > KEY_MAX)))
        |=> (!busy && $stable(done))); // R6

    AST_DONE_FALLS_ON_START: assert property (@(posedge clk) disable iff (rst)
        $fell(done) |-> $past(start)); // R9

endmodule

bind opkey_perm_gen opkey_perm_gen_chk #(
    .KEY_MAX (KEY_MAX),
    .NUM_OPS (NUM_OPS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .key_wr    (key_wr),
    .key_addr  (key_addr),
    .key_byte  (key_byte),
    .key_len   (key_len),
    .start     (start),
    .lu_req    (lu_req),
    .lu_code   (lu_code),
    .busy      (busy),
    .done      (done),
    .lu_rvalid (lu_rvalid),
    .lu_index  (lu_index),
    .lu_known  (lu_known)
);

// File: tb/sim_opkey_perm_gen.sv
`timescale 1ns/1ps
module sim_opkey_perm_gen;

    localparam int KEY_MAX = 16;
    localparam int NUM_OPS = 49;
    localparam int KEY_AW  = $clog2(KEY_MAX);
    localparam int LEN_W   = $clog2(KEY_MAX + 1);
    localparam int DONE_EDGES = 513;

    logic              clk;
    logic              rst;
    logic              key_wr;
    logic [KEY_AW-1:0] key_addr;
    logic [7:0]        key_byte;
    logic [LEN_W-1:0]  key_len;
    logic              start;
    logic              lu_req;
    logic [7:0]        lu_code;
    logic              busy;
    logic              done;
    logic              lu_rvalid;
    logic [7:0]        lu_index;
    logic              lu_known;

    opkey_perm_gen #(
        .KEY_MAX (KEY_MAX),
        .NUM_OPS (NUM_OPS)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .key_wr    (key_wr),
        .key_addr  (key_addr),
        .key_byte  (key_byte),
        .key_len   (key_len),
        .start     (start),
        .lu_req    (lu_req),
        .lu_code   (lu_code),
        .busy      (busy),
        .done      (done),
        .lu_rvalid (lu_rvalid),
        .lu_index  (lu_index),
        .lu_known  (lu_known)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    typedef struct {
        int    index;
        bit    known;
        bit    chk_idx;
        string req;
    } exp_t;

    exp_t  sb[$];
    int    kb[KEY_MAX];
    int    exp_inv[256];
    int    n_run  = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;

    task automatic check(input string req, input string what, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic model(input int len);
        int s[256];
        int j;
        int t;
        for (int i = 0; i < 256; i++) s[i] = i;
        j = 0;
        for (int i = 0; i < 256; i++) begin
            j = (j + s[i] + kb[i % len]) % 256;
            t = s[i];
            s[i] = s[j];
            s[j] = t;
        end
        for (int p = 0; p < 256; p++) exp_inv[s[p]] = p;
    endtask

    task automatic write_key(input int len, input int seed);
        for (int a = 0; a < len; a++) begin
            kb[a]    = (seed * 37 + a * 11 + 5) & 255;
            key_wr   = 1'b1;
            key_addr = KEY_AW'(a);
            key_byte = 8'(kb[a]);
            @(negedge clk);
        end
        key_wr = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n;
        n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(req, "edges to done", n, DONE_EDGES);
    endtask

    task automatic run_shuffle(input int len, input string req);
        key_len = LEN_W'(len);
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        check(req, "busy after start", int'(busy), 1);
        wait_done(req);
    endtask

    task automatic sweep(input string req);
        for (int c = 0; c < 256; c++) begin
            lu_req  = 1'b1;
            lu_code = 8'(c);
            sb.push_back('{index: exp_inv[c], known: (exp_inv[c] < NUM_OPS),
                           chk_idx: 1'b1, req: req});
            @(negedge clk);
        end
        lu_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pops the expected item for each response.
    always @(negedge clk) begin
        if (!rst && lu_rvalid) begin
            if (sb.size() == 0) begin
                check("R4", "unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.req, "known bit", int'(lu_known), int'(e.known));
                if (e.chk_idx) check(e.req, "index", int'(lu_index), e.index);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL R2 watchdog: actual hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; key_wr = 1'b0; key_addr = '0; key_byte = '0;
        key_len = '0; start = 1'b0; lu_req = 1'b0; lu_code = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1", "busy", int'(busy), 0);
        check("R1", "done", int'(done), 0);
        check("R1", "lu_rvalid", int'(lu_rvalid), 0);

        // R5: lookup before any shuffle is not known
        lu_req = 1'b1; lu_code = 8'd5;
        sb.push_back('{index: 0, known: 1'b0, chk_idx: 1'b0, req: "R5"});
        @(negedge clk);
        lu_req = 1'b0;
        @(negedge clk);

        // R6: zero and oversize lengths ignored from idle
        key_len = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R6", "busy after len 0", int'(busy), 0);
        check("R6", "done after len 0", int'(done), 0);
        key_len = LEN_W'(KEY_MAX + 1); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R6", "busy after len 17", int'(busy), 0);

        // R2, R3, R4: five-byte key
        write_key(5, 1);
        model(5);
        run_shuffle(5, "R2");
        sweep("R3");

        // R6: zero length while done keeps done
        key_len = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R6", "done kept", int'(done), 1);
        check("R6", "busy stays low", int'(busy), 0);

        // R3: one-byte key
        write_key(1, 2);
        model(1);
        run_shuffle(1, "R3");
        sweep("R3");

        // R7, R8: full-length key with a start and a key write mid-run
        write_key(KEY_MAX, 4);
        model(KEY_MAX);
        key_len = LEN_W'(KEY_MAX);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        begin
            int n;
            n = 0;
            while (!done && n < 2000) begin
                if (n == 100) begin
                    start = 1'b1; key_len = LEN_W'(3);
                    key_wr = 1'b1; key_addr = '0; key_byte = 8'(kb[0] ^ 8'h5A);
                end else begin
                    start = 1'b0; key_wr = 1'b0;
                end
                @(negedge clk);
                n++;
            end
            start = 1'b0; key_wr = 1'b0;
            check("R7", "edges to done with mid-run start", n, DONE_EDGES);
        end
        sweep("R7");
        run_shuffle(KEY_MAX, "R8");
        sweep("R8");

        // R9: restart and lookup in the same cycle
        write_key(7, 3);
        key_len = LEN_W'(7);
        start   = 1'b1;
        lu_req  = 1'b1;
        lu_code = 8'd77;
        sb.push_back('{index: exp_inv[77], known: (exp_inv[77] < NUM_OPS),
                       chk_idx: 1'b1, req: "R9"});
        @(negedge clk);
        start  = 1'b0;
        lu_req = 1'b0;
        check("R9", "done after restart", int'(done), 0);
        check("R9", "busy after restart", int'(busy), 1);
        wait_done("R9");
        model(7);
        sweep("R9");

        check("R4", "pending responses", sb.size(), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule